// File: doc/BRIEF.md
# Four-Lane Packed INT8 Dual Dot Product

This block forms two four-term dot products that share one operand vector: the sum of a_i·b_i and the sum of a_i·c_i, over four lanes of 8-bit operands. Each lane does a single 18x18-class multiply. The two operands that share a_i are packed into one wide input: b_i sits ten bit positions above c_i. The 26-bit lane product therefore holds both partial products, and the two overlap in six bit positions.

A lane does not untangle its own product. A small truncated multiplier gives the low six bits of a_i·b_i. From that the lane derives a 6-bit correction field and a single borrow bit. The reduction stage then adds each field separately across the four lanes: the low fields of the c-product, the correction fields, the high fields of the wide products, the borrows and the sign fixes. The upper product is repaired only once, on the reduced sums. One sample is taken per cycle. A per-sample mode bit picks unsigned or two's-complement operands, and both results come out 18 bits wide, two clock edges after the sample.

Top module: `int8_dual_dot4`

## Requirements
- R1: With in_signed = 0, all operands are unsigned. dot_ab equals the exact sum of a_i·b_i and dot_ac equals the exact sum of a_i·c_i. Lane i occupies bits [8i+7:8i] of in_a, in_b and in_c.
- R2: With in_signed = 1, all operands are two's complement. Both results are the exact signed sums, given as 18-bit two's complement.
- R3: Unsigned extremes are exact. Every operand at 255 gives 260100 on both outputs.
- R4: Signed extremes are exact. Every operand at -128 gives 65536. a = -128 with the other operand at 127 gives -65024.
- R5: The result is exact when the lane's overlap field borrows. This is the case where the wide product's bits [15:10] are below the low six bits of a_i·b_i. It also holds when the c-product is negative and needs a sign fix in the high field.
- R6: A sample taken at an edge with in_valid high appears on dot_ab and dot_ac, with out_valid high, after the second following edge. out_valid stays high for exactly one cycle per sample.
- R7: The block accepts a new sample on every cycle. Back-to-back samples each produce their own correct result on consecutive cycles.
- R8: An edge with in_valid low does not change dot_ab or dot_ac, whatever the operand inputs are. Both outputs hold the last result while out_valid is low.
- R9: Synchronous active-high reset clears out_valid, dot_ab and dot_ac to zero and drops any sample in flight.
- R10: The signed/unsigned mode is captured with each sample. Adjacent samples with different modes are each computed in their own mode.
- R11: When every a_i is zero, both results are zero, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand sample valid |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| in_a | input | 32 | Shared operands a_0..a_3, 8 bits per lane |
| in_b | input | 32 | Operands b_0..b_3, upper product partner |
| in_c | input | 32 | Operands c_0..c_3, lower product partner |
| out_valid | output | 1 | Result valid, one cycle per sample |
| dot_ab | output | 18 | Sum of a_i·b_i |
| dot_ac | output | 18 | Sum of a_i·c_i |

## Verification
Small hand-picked vectors in each mode show whether the two products are separated correctly when no field overflows. All-extreme operands drive every lane's high field and the output width to their limits. Vectors chosen so that every lane borrows, or every c-product is negative, isolate the deferred borrow count and the sign-fix count from the plain field sums. Long back-to-back random streams with a random mode per sample separate per-sample mode capture and pipeline alignment from the arithmetic itself. Gaps with changing operands and valid low show whether the output registers load only on valid samples.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  // default geometry: four lanes, 8-bit operands, upper operand packed 10 bits up
  localparam int DEF_LANES = 4;
  localparam int DEF_OP_W  = 8;
  localparam int DEF_SHIFT = 10;

  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } num_mode_e;
endpackage

// File: rtl/dotp_packed_mul.sv
// Behavioural wide multiply: a * (b << SHIFT + c), result kept to PROD_W bits.
module dotp_packed_mul #(
  parameter int OP_W  = 8,
  parameter int SHIFT = 10,
  localparam int PROD_W = 2*OP_W + SHIFT
) (
  input  logic              sgn,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic [OP_W-1:0]   c,
  output logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] a_w;
  logic [PROD_W-1:0] q_w;

  assign a_w  = {{(PROD_W-OP_W){sgn & a[OP_W-1]}}, a};
  // packed multiplier input: b in the upper field, c sign-extended underneath
  assign q_w  = {{OP_W{sgn & b[OP_W-1]}}, b, {SHIFT{1'b0}}}
              + {{(PROD_W-OP_W){sgn & c[OP_W-1]}}, c};
  assign prod = a_w * q_w;
endmodule

// File: rtl/dotp_lsb_mul.sv
// Truncated multiplier: only the low W bits of the product.
module dotp_lsb_mul #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] p
);
  assign p = x * y;
endmodule

// File: rtl/dotp_lane.sv
// One lane: packed multiply, split into fields, overlap correction field and borrow.
module dotp_lane #(
  parameter int OP_W  = 8,
  parameter int SHIFT = 10,
  localparam int PROD_W = 2*OP_W + SHIFT,
  localparam int LSB_W  = 2*OP_W - SHIFT,
  localparam int HI_W   = PROD_W - SHIFT - LSB_W
) (
  input  logic             sgn,
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic [OP_W-1:0]  c,
  output logic [SHIFT-1:0] ylo,   // low bits of a*c, final as is
  output logic [LSB_W-1:0] efix,  // upper part of a*c, modulo 2^LSB_W
  output logic             brw,   // borrow out of the overlap field
  output logic [HI_W-1:0]  ohi,   // top field of the wide product
  output logic [LSB_W-1:0] zlo    // low bits of a*b
);
  logic [PROD_W-1:0] prod;
  logic [LSB_W:0]    diff;

  dotp_packed_mul #(.OP_W(OP_W), .SHIFT(SHIFT)) u_mul (
    .sgn (sgn), .a (a), .b (b), .c (c), .prod (prod)
  );

  dotp_lsb_mul #(.W(LSB_W)) u_lsb (
    .x (a[LSB_W-1:0]), .y (b[LSB_W-1:0]), .p (zlo)
  );

  // overlap field = (zlo + efix) mod 2^LSB_W, so efix = field - zlo; keep the borrow
  assign diff = {1'b0, prod[SHIFT+LSB_W-1:SHIFT]} - {1'b0, zlo};
  assign efix = diff[LSB_W-1:0];
  assign brw  = diff[LSB_W];
  assign ylo  = prod[SHIFT-1:0];
  assign ohi  = prod[PROD_W-1:SHIFT+LSB_W];
endmodule

// File: rtl/dotp_reduce.sv
// Field-wise reduction across lanes; upper product repaired once on the sums.
module dotp_reduce #(
  parameter int LANES = 4,
  parameter int OP_W  = 8,
  parameter int SHIFT = 10,
  localparam int LSB_W = 2*OP_W - SHIFT,
  localparam int HI_W  = SHIFT,
  localparam int GROW  = $clog2(LANES),
  localparam int OUT_W = 2*OP_W + GROW
) (
  input  logic                   sgn,
  input  logic [LANES*SHIFT-1:0] ylo_v,
  input  logic [LANES*LSB_W-1:0] efix_v,
  input  logic [LANES-1:0]       brw_v,
  input  logic [LANES*HI_W-1:0]  ohi_v,
  input  logic [LANES*LSB_W-1:0] zlo_v,
  output logic [OUT_W-1:0]       sum_ab,
  output logic [OUT_W-1:0]       sum_ac
);
  localparam int YS_W  = SHIFT + GROW;
  localparam int ES_W  = LSB_W + GROW;
  localparam int HS_W  = HI_W + GROW;
  localparam int CNT_W = GROW + 1;

  logic [YS_W-1:0]  ylo_sum;
  logic [ES_W-1:0]  ef_sum;
  logic [HS_W-1:0]  hi_sum;
  logic [ES_W-1:0]  zl_sum;
  logic [CNT_W-1:0] brw_cnt;
  logic [CNT_W-1:0] sfix_cnt;
  logic [HS_W-1:0]  zhi;
  logic [OUT_W-1:0] ef_ext;

  always_comb begin
    ylo_sum  = '0;
    ef_sum   = '0;
    hi_sum   = '0;
    zl_sum   = '0;
    brw_cnt  = '0;
    sfix_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      ylo_sum  = ylo_sum + YS_W'(ylo_v[i*SHIFT +: SHIFT]);
      ef_sum   = ef_sum + {{GROW{sgn & efix_v[i*LSB_W+LSB_W-1]}}, efix_v[i*LSB_W +: LSB_W]};
      hi_sum   = hi_sum + {{GROW{sgn & ohi_v[i*HI_W+HI_W-1]}}, ohi_v[i*HI_W +: HI_W]};
      zl_sum   = zl_sum + ES_W'(zlo_v[i*LSB_W +: LSB_W]);
      brw_cnt  = brw_cnt + CNT_W'(brw_v[i]);
      // negative c-product: its upper part was taken from the high field one step too low
      sfix_cnt = sfix_cnt + CNT_W'(sgn & efix_v[i*LSB_W+LSB_W-1]);
    end
  end

  // one deferred repair: borrows, sign fixes and the carry out of the low sum
  assign zhi    = hi_sum - HS_W'(brw_cnt) + HS_W'(sfix_cnt)
                + HS_W'(zl_sum[ES_W-1:LSB_W]);
  assign sum_ab = {zhi, zl_sum[LSB_W-1:0]};

  assign ef_ext = {{(OUT_W-ES_W){sgn & ef_sum[ES_W-1]}}, ef_sum};
  assign sum_ac = (ef_ext << SHIFT) + OUT_W'(ylo_sum);
endmodule

// File: rtl/int8_dual_dot4.sv
// Two-stage pipeline: lane products registered, then reduction registered.
module int8_dual_dot4 #(
  parameter int LANES = dotp_pkg::DEF_LANES,
  parameter int OP_W  = dotp_pkg::DEF_OP_W,
  parameter int SHIFT = dotp_pkg::DEF_SHIFT,
  localparam int OUT_W = 2*OP_W + $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_signed,
  input  logic [LANES*OP_W-1:0] in_a,
  input  logic [LANES*OP_W-1:0] in_b,
  input  logic [LANES*OP_W-1:0] in_c,
  output logic                  out_valid,
  output logic [OUT_W-1:0]      dot_ab,
  output logic [OUT_W-1:0]      dot_ac
);
  import dotp_pkg::*;

  localparam int LSB_W = 2*OP_W - SHIFT;
  localparam int HI_W  = SHIFT;

  logic [LANES*SHIFT-1:0] l_ylo, s1_ylo;
  logic [LANES*LSB_W-1:0] l_efix, s1_efix;
  logic [LANES-1:0]       l_brw, s1_brw;
  logic [LANES*HI_W-1:0]  l_ohi, s1_ohi;
  logic [LANES*LSB_W-1:0] l_zlo, s1_zlo;
  logic                   s1_valid;
  num_mode_e              s1_mode;
  logic [OUT_W-1:0]       red_ab, red_ac;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dotp_lane #(.OP_W(OP_W), .SHIFT(SHIFT)) u_lane (
      .sgn  (in_signed),
      .a    (in_a[g*OP_W +: OP_W]),
      .b    (in_b[g*OP_W +: OP_W]),
      .c    (in_c[g*OP_W +: OP_W]),
      .ylo  (l_ylo[g*SHIFT +: SHIFT]),
      .efix (l_efix[g*LSB_W +: LSB_W]),
      .brw  (l_brw[g]),
      .ohi  (l_ohi[g*HI_W +: HI_W]),
      .zlo  (l_zlo[g*LSB_W +: LSB_W])
    );
  end

  // stage 1: lane fields
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_UNS;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_mode <= in_signed ? MODE_SGN : MODE_UNS;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_ylo  <= l_ylo;
      s1_efix <= l_efix;
      s1_brw  <= l_brw;
      s1_ohi  <= l_ohi;
      s1_zlo  <= l_zlo;
    end
  end

  dotp_reduce #(.LANES(LANES), .OP_W(OP_W), .SHIFT(SHIFT)) u_red (
    .sgn    (s1_mode == MODE_SGN),
    .ylo_v  (s1_ylo),
    .efix_v (s1_efix),
    .brw_v  (s1_brw),
    .ohi_v  (s1_ohi),
    .zlo_v  (s1_zlo),
    .sum_ab (red_ab),
    .sum_ac (red_ac)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dot_ab    <= '0;
      dot_ac    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        dot_ab <= red_ab;
        dot_ac <= red_ac;
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid) else $error("valid lost in pipe"); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid) else $error("spurious out_valid"); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(dot_ab) && $stable(dot_ac))) else $error("result moved"); // R8
  AST_ZERO_SHARED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_a == '0) |=> ##1 (dot_ab == '0 && dot_ac == '0)) else $error("zero a nonzero sum"); // R11

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_BRW_EFIX: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_brw[g]) |-> (s1_efix[g*LSB_W +: LSB_W] != '0)) else $error("borrow with zero field"); // R5
  end
endmodule

// File: tb/int8_dual_dot4_tb.sv
module int8_dual_dot4_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int W  = 8;
  localparam int OW = 18;
  localparam int AW = L*W;
  localparam int NS = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_signed = 1'b0;
  logic [AW-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic out_valid;
  logic [OW-1:0] dot_ab, dot_ac;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int8_dual_dot4 u_dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_signed (in_signed),
    .in_a (in_a), .in_b (in_b), .in_c (in_c),
    .out_valid (out_valid), .dot_ab (dot_ab), .dot_ac (dot_ac)
  );

  function automatic logic [OW-1:0] ref_dot(input logic [AW-1:0] x, input logic [AW-1:0] y, input logic sg);
    int acc;
    acc = 0;
    for (int i = 0; i < L; i++) begin
      int xi, yi;
      if (sg) begin
        xi = int'($signed(x[i*W +: W]));
        yi = int'($signed(y[i*W +: W]));
      end else begin
        xi = int'(x[i*W +: W]);
        yi = int'(y[i*W +: W]);
      end
      acc += xi * yi;
    end
    return acc[OW-1:0];
  endfunction

  function automatic logic [AW-1:0] p4(input int v0, input int v1, input int v2, input int v3);
    return {v3[W-1:0], v2[W-1:0], v1[W-1:0], v0[W-1:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [OW-1:0] got, input logic [OW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // one isolated sample: checks latency, pulse width and both sums
  task automatic one_shot(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] c,
                          input logic sg, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_signed = sg; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", "out_valid before latency", {17'd0, out_valid}, 18'd0);
    @(negedge clk);
    chk("R6", "out_valid at latency 2", {17'd0, out_valid}, 18'd1);
    chk(tag, "dot_ab", dot_ab, ref_dot(a, b, sg));
    chk(tag, "dot_ac", dot_ac, ref_dot(a, c, sg));
    @(negedge clk);
    chk("R6", "out_valid single cycle", {17'd0, out_valid}, 18'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "out_valid in reset", {17'd0, out_valid}, 18'd0);
    chk("R9", "dot_ab in reset", dot_ab, 18'd0);
    chk("R9", "dot_ac in reset", dot_ac, 18'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "out_valid after release", {17'd0, out_valid}, 18'd0);
  endtask

  task automatic t_unsigned();
    one_shot(p4(1, 2, 3, 4), p4(5, 6, 7, 8), p4(9, 10, 11, 12), 1'b0, "R1");
    one_shot(p4(200, 17, 99, 3), p4(13, 250, 1, 128), p4(77, 0, 255, 64), 1'b0, "R1");
    one_shot(p4(128, 64, 32, 16), p4(2, 4, 8, 16), p4(255, 1, 128, 7), 1'b0, "R1");
  endtask

  task automatic t_signed();
    one_shot(p4(-3, 5, -7, 9), p4(2, -4, 6, -8), p4(-1, -1, 1, 1), 1'b1, "R2");
    one_shot(p4(100, -100, 50, -50), p4(-90, -90, 120, 3), p4(127, -128, -5, 77), 1'b1, "R2");
  endtask

  task automatic t_extremes();
    one_shot(p4(255, 255, 255, 255), p4(255, 255, 255, 255), p4(255, 255, 255, 255), 1'b0, "R3");
    one_shot(p4(255, 255, 255, 255), p4(0, 0, 0, 0), p4(255, 255, 255, 255), 1'b0, "R3");
    one_shot(p4(-128, -128, -128, -128), p4(-128, -128, -128, -128), p4(-128, -128, -128, -128), 1'b1, "R4");
    one_shot(p4(-128, -128, -128, -128), p4(127, 127, 127, 127), p4(-128, -128, -128, -128), 1'b1, "R4");
    one_shot(p4(127, 127, 127, 127), p4(-128, -128, -128, -128), p4(127, 127, 127, 127), 1'b1, "R4");
  endtask

  task automatic t_borrow();
    one_shot(p4(255, 255, 255, 255), p4(1, 1, 1, 1), p4(255, 255, 255, 255), 1'b0, "R5");
    one_shot(p4(1, 1, 1, 1), p4(0, 0, 0, 0), p4(-1, -1, -1, -1), 1'b1, "R5");
    one_shot(p4(-1, -1, -1, -1), p4(-1, -1, -1, -1), p4(1, 1, 1, 1), 1'b1, "R5");
    one_shot(p4(-1, 3, -128, 127), p4(-1, 21, 1, -3), p4(1, -100, 127, -128), 1'b1, "R5");
  endtask

  task automatic t_zero_a();
    one_shot(p4(0, 0, 0, 0), p4(255, 17, 128, 9), p4(200, 1, 255, 64), 1'b0, "R11");
    one_shot(p4(0, 0, 0, 0), p4(-128, 17, -1, 9), p4(-128, 1, 127, -64), 1'b1, "R11");
  endtask

  // back-to-back samples; mode per sample random when mix is set
  task automatic t_stream(input bit mix, input logic base_sg);
    logic [AW-1:0] va [NS];
    logic [AW-1:0] vb [NS];
    logic [AW-1:0] vc [NS];
    logic          vs [NS];
    for (int j = 0; j < NS; j++) begin
      va[j] = $urandom; vb[j] = $urandom; vc[j] = $urandom;
      vs[j] = mix ? 1'($urandom & 1) : base_sg;
    end
    for (int j = 0; j < NS + 2; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk("R7", "stream out_valid", {17'd0, out_valid}, 18'd1);
        chk(mix ? "R10" : "R7", "stream dot_ab", dot_ab, ref_dot(va[j-2], vb[j-2], vs[j-2]));
        chk(mix ? "R10" : "R7", "stream dot_ac", dot_ac, ref_dot(va[j-2], vc[j-2], vs[j-2]));
      end
      if (j < NS) begin
        in_valid = 1'b1; in_signed = vs[j]; in_a = va[j]; in_b = vb[j]; in_c = vc[j];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R6", "stream end out_valid", {17'd0, out_valid}, 18'd0);
  endtask

  task automatic t_hold();
    logic [OW-1:0] eab, eac;
    one_shot(p4(9, 8, 7, 6), p4(5, 4, 3, 2), p4(1, 2, 3, 4), 1'b0, "R8");
    eab = ref_dot(p4(9, 8, 7, 6), p4(5, 4, 3, 2), 1'b0);
    eac = ref_dot(p4(9, 8, 7, 6), p4(1, 2, 3, 4), 1'b0);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b0; in_signed = 1'($urandom & 1);
      in_a = $urandom; in_b = $urandom; in_c = $urandom;
      @(negedge clk);
      chk("R8", "out_valid with valid low", {17'd0, out_valid}, 18'd0);
      chk("R8", "dot_ab held", dot_ab, eab);
      chk("R8", "dot_ac held", dot_ac, eac);
    end
  endtask

  task automatic t_midreset();
    @(negedge clk);
    in_valid = 1'b1; in_signed = 1'b0;
    in_a = p4(10, 20, 30, 40); in_b = p4(1, 1, 1, 1); in_c = p4(2, 2, 2, 2);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R9", "in-flight sample dropped", {17'd0, out_valid}, 18'd0);
    chk("R9", "dot_ab cleared", dot_ab, 18'd0);
    chk("R9", "dot_ac cleared", dot_ac, 18'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "no late valid", {17'd0, out_valid}, 18'd0);
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_extremes();
    t_borrow();
    t_zero_a();
    t_stream(1'b0, 1'b0);
    t_stream(1'b0, 1'b1);
    t_stream(1'b1, 1'b0);
    t_hold();
    t_midreset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R6 watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule